// File: doc/BRIEF.md
# Three-Channel Prescaler and Programmable Timer

The block holds three 8-bit up-counters that advance on single-cycle count strobes in the system clock domain. The first counter is free-running. It advances on a 32768 Hz tick strobe and wraps every 256 ticks. The other two counters each divide their selected input by a factor held in their own limit register. Every counter emits a one-cycle event strobe when it returns to zero. The interrupt controller collects these strobes as request flags.

One control byte chooses the input source of each programmable counter and holds a clear bit and an enable bit for each. In one source setting the third counter counts the second counter's event strobe. In that cascade setting the clear and enable bits act on both counters together, and the two freed bits choose which external pin feeds the second counter. All registers sit behind a plain register port. Writes take one clock, and reads are combinational.

Top module: `tmr_unit`

## Requirements
- R1: After reset the control byte, both limit registers and all three counts read 0x00. Both flag-clear outputs are low.
- R2: The free-running counter (address 1) adds one per `tick_i` strobe. On the strobe that takes it from 255 to 0 it raises `t1_evt_o` for exactly one cycle.
- R3: While `halt_i` is high the free-running counter is forced to zero and stays there whatever ticks arrive. Counting resumes from zero after `halt_i` falls.
- R4: A programmable counter whose limit register holds K (1..255) counts 0..K-1. On the count that would reach K it returns to 0 and raises its event strobe for one cycle. K = 0 divides by 256.
- R5: Control bits [5:4] choose the second counter's source: 00 is the first counter's wrap strobe, 01 is each rising edge of the first counter's bit 3, 10 is `tune_tick_i`, and 11 is an external pin. Outside cascade that pin is IN6 (`ext_i[0]`).
- R6: Control bits [7:6] choose the third counter's source: 00 is the wrap strobe, 01 is the rising edge of the first counter's bit 3, 10 is the second counter's event (cascade), and 11 is IN6.
- R7: Outside cascade, bit 3 clears the third counter and bit 2 clears the second. A cleared counter is held at zero and drives its flag-clear output high. Bit 1 enables the third counter and bit 0 enables the second. A disabled counter holds its value.
- R8: In cascade, bit 2 clears both counters and raises both flag-clear outputs, and bit 0 enables both. `t2_evt_o` stays low although the third counter still counts the second's events.
- R9: In cascade with the second counter on its external source, bits {3,1} choose the pin: 00 is IN7 (`ext_i[1]`), 01 is IN6 (`ext_i[0]`), and 1x is IN8 (`ext_i[2]`).
- R10: With the second counter on `tune_tick_i`, it counts and wraps as in R4, but `t2_evt_o` stays low.
- R11: The register map is: 0 control (read/write), 1/2/3 the three counts (read-only, writes ignored), 4 and 5 the second and third limit registers (read/write). Addresses 6 and 7 read 0x00.
- R12: External pins are synchronised. Each rising edge on a selected pin adds exactly one count, however long the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32768 Hz count strobe, one cycle wide |
| tune_tick_i | input | 1 | Tune-rate count strobe, one cycle wide |
| halt_i | input | 1 | Hold the free-running counter at zero |
| ext_i | input | 3 | External pins: [0] IN6, [1] IN7, [2] IN8 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data (combinational) |
| t1_evt_o | output | 1 | Free-running counter wrap strobe |
| t2_evt_o | output | 1 | Second counter event strobe (gated) |
| t3_evt_o | output | 1 | Third counter event strobe |
| t2_flag_clr_o | output | 1 | Second counter's flag must be cleared |
| t3_flag_clr_o | output | 1 | Third counter's flag must be cleared |

## Verification
A register write shows on the next read. A `tick_i` or `tune_tick_i` strobe updates its count one cycle later. A rising edge of the first counter's bit 3 reaches the selected counter one cycle after that. A pin edge needs three clock edges (two synchroniser stages and the edge register) before the count moves. Event strobes rise in the same cycle that their count returns to zero, and a cascaded third counter moves one cycle after the second counter's strobe. The bench drives inputs on falling edges, waits at least four cycles after each burst before reading counts, and counts event strobes at falling edges, taking the difference across each burst.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    SRC_WRAP = 2'b00,
    SRC_TAP  = 2'b01,
    SRC_ALT  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM2 = 3'd4;
  localparam logic [ADDR_W-1:0] A_LIM3 = 3'd5;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_divcnt.sv
module tmr_divcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         evt_o
);
  logic [W-1:0] last_val;
  logic         at_end;

  // limit 0 wraps to all ones, so K = 0 gives a divide by 2**W
  assign last_val = limit_i - 1'b1;
  assign at_end   = (cnt_o == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      evt_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (en_i && inc_i) begin
        if (at_end) begin
          cnt_o <= '0;
          evt_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end

  assert_clear_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0) && !evt_o);
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(en_i && inc_i)) |=> $stable(cnt_o));
  assert_evt_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (cnt_o == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_PINS      = 3,
  parameter int unsigned TAP_BIT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tune_tick_i,
  input  logic              halt_i,
  input  logic [N_PINS-1:0] ext_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              t1_evt_o,
  output logic              t2_evt_o,
  output logic              t3_evt_o,
  output logic              t2_flag_clr_o,
  output logic              t3_flag_clr_o
);
  logic [CNT_W-1:0]  ctrl_q, lim2_q, lim3_q;
  logic [CNT_W-1:0]  cnt1, cnt2, cnt3;
  logic              t2_raw_evt;
  logic [N_PINS-1:0] pin_rise;
  logic              tap_q, tap_rise;
  src_e              sel2, sel3;
  logic              cascade;
  logic              inc2, inc3, en2, en3, clr2, clr3, pin2;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim2_q <= '0;
      lim3_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q <= wr_data_i;
        A_LIM2:  lim2_q <= wr_data_i;
        A_LIM3:  lim3_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_CNT1:  rd_data_o = cnt1;
      A_CNT2:  rd_data_o = cnt2;
      A_CNT3:  rd_data_o = cnt3;
      A_LIM2:  rd_data_o = lim2_q;
      A_LIM3:  rd_data_o = lim3_q;
      default: rd_data_o = '0;
    endcase
  end

  // pin synchronisers
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_i[g]), .rise_o(pin_rise[g]));
  end

  // free-running prescaler
  tmr_divcnt #(.W(CNT_W)) cnt1_i (
    .clk(clk), .rst_n(rst_n), .inc_i(tick_i), .en_i(1'b1), .clr_i(halt_i),
    .limit_i('0), .cnt_o(cnt1), .evt_o(t1_evt_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= cnt1[TAP_BIT];
  end
  assign tap_rise = cnt1[TAP_BIT] & ~tap_q;

  // control decode, including the cascade remap
  assign sel3    = src_e'(ctrl_q[7:6]);
  assign sel2    = src_e'(ctrl_q[5:4]);
  assign cascade = (sel3 == SRC_ALT);
  assign en2     = ctrl_q[0];
  assign en3     = cascade ? ctrl_q[0] : ctrl_q[1];
  assign clr2    = ctrl_q[2];
  assign clr3    = cascade ? ctrl_q[2] : ctrl_q[3];
  assign pin2    = !cascade  ? pin_rise[0] :
                   ctrl_q[3] ? pin_rise[2] :
                   ctrl_q[1] ? pin_rise[0] : pin_rise[1];

  always_comb begin
    case (sel2)
      SRC_WRAP: inc2 = t1_evt_o;
      SRC_TAP:  inc2 = tap_rise;
      SRC_ALT:  inc2 = tune_tick_i;
      default:  inc2 = pin2;
    endcase
    case (sel3)
      SRC_WRAP: inc3 = t1_evt_o;
      SRC_TAP:  inc3 = tap_rise;
      SRC_ALT:  inc3 = t2_raw_evt;
      default:  inc3 = pin_rise[0];
    endcase
  end

  tmr_divcnt #(.W(CNT_W)) cnt2_i (
    .clk(clk), .rst_n(rst_n), .inc_i(inc2), .en_i(en2), .clr_i(clr2),
    .limit_i(lim2_q), .cnt_o(cnt2), .evt_o(t2_raw_evt));

  tmr_divcnt #(.W(CNT_W)) cnt3_i (
    .clk(clk), .rst_n(rst_n), .inc_i(inc3), .en_i(en3), .clr_i(clr3),
    .limit_i(lim3_q), .cnt_o(cnt3), .evt_o(t3_evt_o));

  assign t2_evt_o      = t2_raw_evt & ~cascade & (sel2 != SRC_ALT);
  assign t2_flag_clr_o = clr2;
  assign t3_flag_clr_o = clr3;

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (cnt1 == '0));
  assert_cascade_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && ctrl_q[2]) |=> (cnt2 == '0) && (cnt3 == '0));
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, tune_tick_i = 1'b0, halt_i = 1'b0;
  logic [2:0] ext_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       t1_evt_o, t2_evt_o, t3_evt_o, t2_flag_clr_o, t3_flag_clr_o;

  int nchk = 0, nerr = 0;
  int e1 = 0, e2 = 0, e3 = 0;

  always #2.5 clk = ~clk;

  tmr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tune_tick_i(tune_tick_i),
    .halt_i(halt_i), .ext_i(ext_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .t1_evt_o(t1_evt_o),
    .t2_evt_o(t2_evt_o), .t3_evt_o(t3_evt_o), .t2_flag_clr_o(t2_flag_clr_o),
    .t3_flag_clr_o(t3_flag_clr_o));

  always @(negedge clk) if (rst_n) begin
    if (t1_evt_o) e1++;
    if (t2_evt_o) e2++;
    if (t3_evt_o) e3++;
  end

  // {limit, inputs, expected count, expected events}
  localparam logic [31:0] VEC [7] = '{
    {8'd5,   8'd12, 8'd2,  8'd2},
    {8'd1,   8'd3,  8'd0,  8'd3},
    {8'd0,   8'd20, 8'd20, 8'd0},
    {8'd255, 8'd20, 8'd20, 8'd0},
    {8'd3,   8'd9,  8'd0,  8'd3},
    {8'd7,   8'd6,  8'd6,  8'd0},
    {8'd2,   8'd17, 8'd1,  8'd8}
  };

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); addr_i = a; #1 d = int'(rd_data_o);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic tunes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tune_tick_i = 1'b1;
      @(negedge clk); tune_tick_i = 1'b0;
    end
  endtask

  task automatic pin(input int idx);
    @(negedge clk); ext_i[idx] = 1'b1;
    repeat (6) @(negedge clk);
    ext_i[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic halt_pulse();
    @(negedge clk); halt_i = 1'b1;
    repeat (2) @(negedge clk);
    halt_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int v, base, base3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reg", v, 0);
    end
    check("R1 clr2", int'(t2_flag_clr_o), 0);
    check("R1 clr3", int'(t3_flag_clr_o), 0);

    // vector table: second counter on bit-3 edges of the free-running counter (R4 R5)
    foreach (VEC[k]) begin
      wr(3'd0, 8'h14);
      wr(3'd4, VEC[k][31:24]);
      halt_pulse();
      wr(3'd0, 8'h11);
      base = e2;
      ticks(16 * int'(VEC[k][23:16]));
      settle();
      rd(3'd2, v);
      check("R4 table count", v, int'(VEC[k][15:8]));
      check("R5 table events", e2 - base, int'(VEC[k][7:0]));
    end

    // R2: free-running counter
    wr(3'd0, 8'h00);
    halt_pulse();
    ticks(32); settle();
    rd(3'd1, v); check("R2 count", v, 32);
    base = e1;
    ticks(224); settle();
    rd(3'd1, v); check("R2 wrap", v, 0);
    check("R2 wrap strobe", e1 - base, 1);
    ticks(5); settle();
    rd(3'd1, v); check("R2 after wrap", v, 5);

    // R3: halt clears and holds
    @(negedge clk); halt_i = 1'b1;
    ticks(10); settle();
    rd(3'd1, v); check("R3 held", v, 0);
    halt_i = 1'b0;
    ticks(3); settle();
    rd(3'd1, v); check("R3 resume", v, 3);

    // R11: read-only counts, map
    wr(3'd1, 8'h55); settle();
    rd(3'd1, v); check("R11 cnt1 ro", v, 3);
    wr(3'd0, 8'h04);
    wr(3'd2, 8'h55);
    rd(3'd2, v); check("R11 cnt2 ro", v, 0);
    wr(3'd5, 8'hA7);
    rd(3'd5, v); check("R11 lim3", v, 8'hA7);
    rd(3'd0, v); check("R11 ctrl", v, 8'h04);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); check("R11 addr6", v, 0);

    // R10: tune source, strobe suppressed
    wr(3'd4, 8'd3);
    wr(3'd0, 8'h24);
    wr(3'd0, 8'h21);
    base = e2;
    tunes(7); settle();
    rd(3'd2, v); check("R10 count", v, 1);
    check("R10 no strobe", e2 - base, 0);

    // R7: independent clear and enable
    wr(3'd0, 8'h29); settle();
    check("R7 clr3 out", int'(t3_flag_clr_o), 1);
    check("R7 clr2 out", int'(t2_flag_clr_o), 0);
    tunes(1); settle();
    rd(3'd2, v); check("R7 t2 unaffected", v, 2);
    wr(3'd0, 8'h20);
    tunes(3); settle();
    rd(3'd2, v); check("R7 disabled hold", v, 2);
    wr(3'd0, 8'h24); settle();
    rd(3'd2, v); check("R7 clear t2", v, 0);
    check("R7 clr2 high", int'(t2_flag_clr_o), 1);

    // R6: third counter on wrap strobe, limit 2
    wr(3'd5, 8'd2);
    wr(3'd0, 8'h08);
    halt_pulse();
    wr(3'd0, 8'h02);
    base3 = e3;
    ticks(512); settle();
    rd(3'd3, v); check("R6 wrap src", v, 0);
    check("R4 t3 strobe", e3 - base3, 1);
    ticks(256); settle();
    rd(3'd3, v); check("R6 wrap src 2", v, 1);

    // R6: third counter on bit-3 edges
    wr(3'd5, 8'd0);
    wr(3'd0, 8'h48);
    halt_pulse();
    wr(3'd0, 8'h42);
    ticks(48); settle();
    rd(3'd3, v); check("R6 tap src", v, 3);

    // R6 R12: third counter on IN6
    wr(3'd0, 8'hC8);
    wr(3'd0, 8'hC2);
    pin(0); pin(0); pin(1);
    rd(3'd3, v); check("R12 in6 edges", v, 2);

    // R5: second counter on its pin outside cascade is IN6
    wr(3'd4, 8'd0);
    wr(3'd0, 8'h34);
    wr(3'd0, 8'h31);
    pin(0); pin(2);
    rd(3'd2, v); check("R5 pin in6", v, 1);

    // R8: cascade
    wr(3'd4, 8'd2);
    wr(3'd5, 8'd4);
    wr(3'd0, 8'h95); settle();
    check("R8 clr2 out", int'(t2_flag_clr_o), 1);
    check("R8 clr3 out", int'(t3_flag_clr_o), 1);
    halt_pulse();
    wr(3'd0, 8'h91);
    base = e2; base3 = e3;
    ticks(96); settle();
    rd(3'd2, v); check("R8 t2", v, 0);
    rd(3'd3, v); check("R8 t3 cascade", v, 3);
    check("R8 t2 strobe gated", e2 - base, 0);
    check("R8 t3 strobe", e3 - base3, 0);
    wr(3'd0, 8'h90);
    ticks(32); settle();
    rd(3'd3, v); check("R8 joint disable", v, 3);
    wr(3'd0, 8'h95); settle();
    rd(3'd2, v); check("R8 joint clear t2", v, 0);
    rd(3'd3, v); check("R8 joint clear t3", v, 0);

    // R9: cascade pin select
    wr(3'd4, 8'd0);
    wr(3'd0, 8'hB1);
    pin(1); pin(1); pin(0);
    rd(3'd2, v); check("R9 sel IN7", v, 2);
    wr(3'd0, 8'hB5);
    wr(3'd0, 8'hB3);
    pin(0); pin(2);
    rd(3'd2, v); check("R9 sel IN6", v, 1);
    wr(3'd0, 8'hB5);
    wr(3'd0, 8'hB9);
    pin(2); pin(2); pin(2); pin(1);
    rd(3'd2, v); check("R9 sel IN8", v, 3);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule